// File: doc/BRIEF.md
# Dual-Line Edge-Triggered Interrupt Source Bank

This block collects up to 24 interrupt sources into two host interrupt lines. Each source passes through a two-flop synchronizer. An edge detector then compares the synchronized sample with the one from the cycle before. Two edge-select bits per source decide whether a rising edge, a falling edge or both produce an event. When both bits are clear, the source stays silent. Each line has its own copy of the status and mask registers. The edge-select table is common to both lines.

Every status bit is driven by a small per-source state machine with three states:
- `SRC_CLEAR`: nothing is pending.
- `SRC_PEND`: the status bit is set.
- `SRC_HELD`: the status bit is set and a second event is buffered behind it.

Its transitions are:
- *latch* (CLEAR→PEND on an event).
- *buffer* (PEND→HELD on an event while pending-disable is off).
- *drop* (PEND→CLEAR on a clear with no new event).
- *relatch* (PEND→PEND on a clear that coincides with an event).
- *reappear* (HELD→PEND on a clear).
- *rebuffer* (HELD→HELD on a clear that coincides with a bufferable event).
- *hold* (every other case keeps the state).

A control bit selects how status is acknowledged: clear-on-read, or write-one-to-clear.

The host reaches the registers through a byte-wide port with write and read strobes. Read data is returned combinationally. Each line drives an active-low summary output. A primary aggregator consumes these outputs.

Top module: `sih_bank`

## Requirements
- R1: After reset the following hold:
  - Status registers read 0.
  - Mask registers read 1 in every implemented source bit and 0 in unused bits.
  - Edge-select and control registers read 0.
  - Both `irq_a_n` and `irq_b_n` are high.
- R2: Source i is configured through edge-select byte i/4 at address 0x10+i/4. Bit 2*(i mod 4)+1 of that byte enables rising-edge detection, and bit 2*(i mod 4) enables falling-edge detection.
- R3: A source whose two edge-select bits are both 0 never sets a status bit, whatever its input does.
- R4: A change on `src_in` sets the status bit on the third rising clock edge after the change.
- R5: The two lines are independent:
  - An edge event sets the status bit on both lines.
  - Line A has status at 0x00.. and mask at 0x04...
  - Line B has status at 0x08.. and mask at 0x0C...
  - Clearing or masking on one line has no effect on the other.
- R6: `irq_a_n` / `irq_b_n` is low exactly while that line has a status bit set whose mask bit is 0. A mask bit of 1 blocks its source.
- R7: With control bit 0 (clear-on-read, control address 0x1F) set, a strobed read of a status byte clears the bits it returns. Writes to status registers are then ignored.
- R8: With control bit 0 clear, writing 1 to a status bit clears it, and reads do not clear.
- R9: With control bit 1 (pending-disable) clear, a second event on a source whose status bit is set is buffered. The bit reads set again after the first clear, so a second clear is needed.
- R10: With control bit 1 set, a second event on a pending source is discarded, and one clear suffices.
- R11: An event arriving in the same cycle as a clear of that status bit leaves the bit set.
- R12: Writing 1 to bit k of software-set byte b (address 0x18+b) sets the status bit of source 8*b+k on both lines, as an event would.
- R13: Registers are laid out least-significant byte first:
  - Status and mask registers take ceil(N/8) bytes; edge-select takes ceil(2N/8) bytes.
  - Unimplemented bits read 0, and unmapped addresses read 0.
  - The control register reads back its two bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | N_SRC | Raw interrupt source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables clear-on-read) |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_a_n | output | 1 | Active-low summary of line A |
| irq_b_n | output | 1 | Active-low summary of line B |

## Verification
Results fall due at three distinct points:
- A source input change appears in status, and on the summary outputs, after the third rising edge following it.
- A register write or strobed read takes effect at the rising edge where the strobe is sampled. Its result is visible before the next falling edge.
- Read data follows the address within the same cycle.

The bench drives its inputs one nanosecond after each rising edge and compares every output at the falling edge. The comparison is against a behavioural model that advances once per rising edge. Directed checks sample at exactly those falling edges, including the edges immediately before and after the latching edge, to pin the three-edge latency.

// File: rtl/sih_pkg.sv
package sih_pkg;
    typedef enum logic [1:0] {
        SRC_CLEAR = 2'd0,
        SRC_PEND  = 2'd1,
        SRC_HELD  = 2'd2
    } src_state_e;

    localparam int ADDR_W     = 5;
    localparam int ST_A_BASE  = 0;
    localparam int MK_A_BASE  = 4;
    localparam int ST_B_BASE  = 8;
    localparam int MK_B_BASE  = 12;
    localparam int EDGE_BASE  = 16;
    localparam int SWSET_BASE = 24;
    localparam int CTRL_ADDR  = 31;
    localparam int CTRL_COR   = 0;
    localparam int CTRL_PDIS  = 1;
endpackage

// File: rtl/sih_edge_detect.sv
module sih_edge_detect #(
    parameter int N_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_in,
    input  logic [2*N_SRC-1:0] edge_cfg,
    output logic [N_SRC-1:0]   event_o
);
    logic [N_SRC-1:0] meta_q, sync_q, prev_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
            warm_q <= 2'd0;
        end else begin
            meta_q <= src_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign event_o[i] = (edge_cfg[2*i+1] &  sync_q[i] & ~prev_q[i])
                          | (edge_cfg[2*i]   & ~sync_q[i] &  prev_q[i]);

        // R4
        ev_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && event_o[i]) |-> ($past(src_in[i], 2) != $past(src_in[i], 3)));
    end
endmodule

// File: rtl/sih_pend_fsm.sv
module sih_pend_fsm
    import sih_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic clr,
    input  logic pend_dis,
    output logic pending
);
    src_state_e state_q, state_d;
    logic       bufferable;

    assign bufferable = ev & ~pend_dis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_CLEAR: if (ev) state_d = SRC_PEND;
            SRC_PEND: begin
                if (clr)             state_d = ev ? SRC_PEND : SRC_CLEAR;
                else if (bufferable) state_d = SRC_HELD;
            end
            SRC_HELD: if (clr && !bufferable) state_d = SRC_PEND;
            default:  state_d = SRC_CLEAR;
        endcase
    end

    always_comb pending = (state_q != SRC_CLEAR);

    // R9
    held_reappear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_HELD && clr) |=> pending);
    // R10
    pend_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_dis && state_q != SRC_HELD) |=> (state_q != SRC_HELD));
    // R11
    clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_PEND && clr && ev) |=> pending);
    // R8
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_PEND && clr && !ev) |=> !pending);
endmodule

// File: rtl/sih_line.sv
module sih_line
    import sih_pkg::*;
#(
    parameter int N_SRC   = 12,
    parameter int ST_BASE = 0,
    parameter int MK_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  ev,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              cor,
    input  logic              pend_dis,
    output logic [N_SRC-1:0]  status,
    output logic [N_SRC-1:0]  mask,
    output logic              irq_n
);
    logic [N_SRC-1:0] clr;

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            clr[i] = (reg_addr == ADDR_W'(ST_BASE + i / 8)) &&
                     ((cor && reg_rd && status[i]) ||
                      (!cor && reg_wr && reg_wdata[i % 8]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (reg_wr && reg_addr == ADDR_W'(MK_BASE + i / 8))
                    mask[i] <= reg_wdata[i % 8];
            end
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_fsm
        sih_pend_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev[i]),
            .clr      (clr[i]),
            .pend_dis (pend_dis),
            .pending  (status[i])
        );
    end

    always_comb irq_n = ~|(status & ~mask);

    // R7
    cor_ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor && reg_wr && !reg_rd && reg_addr == ADDR_W'(ST_BASE) && status[0]) |=> status[0]);
endmodule

// File: rtl/sih_bank.sv
module sih_bank
    import sih_pkg::*;
#(
    parameter int N_SRC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_a_n,
    output logic              irq_b_n
);
    localparam int IXR_BYTES = (N_SRC + 7) / 8;
    localparam int EDR_BYTES = (2 * N_SRC + 7) / 8;
    localparam int IXR_W     = IXR_BYTES * 8;
    localparam int EDR_W     = EDR_BYTES * 8;

    logic [2*N_SRC-1:0] edge_q;
    logic [1:0]         ctrl_q;
    logic [N_SRC-1:0]   ev_pin, ev_sw, ev_all;
    logic [N_SRC-1:0]   st_a, st_b, mk_a, mk_b;
    logic [IXR_W-1:0]   pad_sa, pad_sb, pad_ma, pad_mb;
    logic [EDR_W-1:0]   pad_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            ctrl_q <= '0;
        end else if (reg_wr) begin
            for (int j = 0; j < 2 * N_SRC; j++) begin
                if (reg_addr == ADDR_W'(EDGE_BASE + j / 8)) edge_q[j] <= reg_wdata[j % 8];
            end
            if (reg_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= reg_wdata[1:0];
        end
    end

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            ev_sw[i] = reg_wr && (reg_addr == ADDR_W'(SWSET_BASE + i / 8)) && reg_wdata[i % 8];
        end
    end

    assign ev_all = ev_pin | ev_sw;

    sih_edge_detect #(.N_SRC(N_SRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .edge_cfg (edge_q),
        .event_o  (ev_pin)
    );

    sih_line #(.N_SRC(N_SRC), .ST_BASE(ST_A_BASE), .MK_BASE(MK_A_BASE)) u_line_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_all),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cor       (ctrl_q[CTRL_COR]),
        .pend_dis  (ctrl_q[CTRL_PDIS]),
        .status    (st_a),
        .mask      (mk_a),
        .irq_n     (irq_a_n)
    );

    sih_line #(.N_SRC(N_SRC), .ST_BASE(ST_B_BASE), .MK_BASE(MK_B_BASE)) u_line_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_all),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cor       (ctrl_q[CTRL_COR]),
        .pend_dis  (ctrl_q[CTRL_PDIS]),
        .status    (st_b),
        .mask      (mk_b),
        .irq_n     (irq_b_n)
    );

    always_comb begin
        pad_sa = '0;  pad_sa[N_SRC-1:0] = st_a;
        pad_sb = '0;  pad_sb[N_SRC-1:0] = st_b;
        pad_ma = '0;  pad_ma[N_SRC-1:0] = mk_a;
        pad_mb = '0;  pad_mb[N_SRC-1:0] = mk_b;
        pad_edge = '0; pad_edge[2*N_SRC-1:0] = edge_q;
        reg_rdata = '0;
        for (int b = 0; b < IXR_BYTES; b++) begin
            if (reg_addr == ADDR_W'(ST_A_BASE + b)) reg_rdata = pad_sa[b*8 +: 8];
            if (reg_addr == ADDR_W'(MK_A_BASE + b)) reg_rdata = pad_ma[b*8 +: 8];
            if (reg_addr == ADDR_W'(ST_B_BASE + b)) reg_rdata = pad_sb[b*8 +: 8];
            if (reg_addr == ADDR_W'(MK_B_BASE + b)) reg_rdata = pad_mb[b*8 +: 8];
        end
        for (int b = 0; b < EDR_BYTES; b++) begin
            if (reg_addr == ADDR_W'(EDGE_BASE + b)) reg_rdata = pad_edge[b*8 +: 8];
        end
        if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = {6'b0, ctrl_q};
    end

    // R12
    swset_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(SWSET_BASE) && reg_wdata[0]) |=> (st_a[0] && st_b[0]));
    // R5
    line_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd && reg_wr && reg_addr == ADDR_W'(ST_A_BASE) && st_b[0]) |=> st_b[0]);
endmodule

// File: tb/tb_sih_bank.sv
`timescale 1ns/1ps
module tb_sih_bank;
    localparam int N = 12;
    localparam time CYC = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq_a_n, irq_b_n;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    string tag = "R1";

    always #(CYC/2) clk = ~clk;

    sih_bank #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .reg_wr(wr), .reg_rd(rd),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    // behavioural reference model
    logic [N-1:0]   m_st [2];
    logic [N-1:0]   m_hd [2];
    logic [N-1:0]   m_mk [2];
    logic [2*N-1:0] m_edg;
    logic           m_cor, m_pd;
    logic [N-1:0]   s1, s2, s3, ev_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 2; l++) begin
                m_st[l] = '0; m_hd[l] = '0; m_mk[l] = '1;
            end
            m_edg = '0; m_cor = 0; m_pd = 0; s1 = '0; s2 = '0; s3 = '0;
        end else begin
            for (int i = 0; i < N; i++)
                ev_m[i] = (m_edg[2*i+1] && s2[i] && !s3[i]) || (m_edg[2*i] && !s2[i] && s3[i]) ||
                          (wr && addr == 5'(24 + i/8) && wdata[i%8]);
            for (int l = 0; l < 2; l++) begin
                for (int i = 0; i < N; i++) begin
                    bit c, e, keep;
                    c = (addr == 5'((l ? 8 : 0) + i/8)) && ((m_cor && rd) || (!m_cor && wr && wdata[i%8]));
                    e = ev_m[i];
                    keep = e && !m_pd;
                    if (!m_st[l][i]) m_st[l][i] = e;
                    else if (!m_hd[l][i]) begin
                        if (c) m_st[l][i] = e;
                        else if (keep) m_hd[l][i] = 1'b1;
                    end else if (c && !keep) m_hd[l][i] = 1'b0;
                end
            end
            if (wr) begin
                for (int i = 0; i < N; i++) begin
                    if (addr == 5'(4 + i/8))  m_mk[0][i] = wdata[i%8];
                    if (addr == 5'(12 + i/8)) m_mk[1][i] = wdata[i%8];
                end
                for (int j = 0; j < 2*N; j++)
                    if (addr == 5'(16 + j/8)) m_edg[j] = wdata[j%8];
                if (addr == 5'd31) begin m_cor = wdata[0]; m_pd = wdata[1]; end
            end
            s3 = s2; s2 = s1; s1 = src;
        end
    end

    function automatic logic [7:0] model_rd(input logic [4:0] a);
        logic [15:0] sa, sb, ma, mb;
        logic [23:0] ed;
        sa = 16'(m_st[0]); sb = 16'(m_st[1]); ma = 16'(m_mk[0]); mb = 16'(m_mk[1]);
        ed = m_edg;
        case (a)
            5'h00: return sa[7:0];   5'h01: return sa[15:8];
            5'h04: return ma[7:0];   5'h05: return ma[15:8];
            5'h08: return sb[7:0];   5'h09: return sb[15:8];
            5'h0C: return mb[7:0];   5'h0D: return mb[15:8];
            5'h10: return ed[7:0];   5'h11: return ed[15:8];  5'h12: return ed[23:16];
            5'h1F: return {6'b0, m_pd, m_cor};
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        if (armed && rst_n) begin
            logic [7:0] e;
            logic ea, eb;
            e  = model_rd(addr);
            ea = ~|(m_st[0] & ~m_mk[0]);
            eb = ~|(m_st[1] & ~m_mk[1]);
            checks++;
            if (rdata !== e || irq_a_n !== ea || irq_b_n !== eb) begin
                errors++;
                $display("FAIL %s model compare @%0t: rdata=%h irq=%b%b expected rdata=%h irq=%b%b",
                         tag, $time, rdata, irq_a_n, irq_b_n, e, ea, eb);
            end
        end
    end

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h @%0t", t, act, exp, $time);
        end
    endtask

    task automatic wreg(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #1; wr = 1; rd = 0; addr = a; wdata = d;
        @(posedge clk); #1; wr = 0;
    endtask

    task automatic peek(input logic [4:0] a);
        @(posedge clk); #1; wr = 0; rd = 0; addr = a;
        @(negedge clk);
    endtask

    task automatic rreg(input logic [4:0] a, output logic [7:0] d);
        @(posedge clk); #1; wr = 0; rd = 1; addr = a;
        @(negedge clk); d = rdata;
        @(posedge clk); #1; rd = 0;
    endtask

    task automatic setsrc(input logic [N-1:0] v);
        @(posedge clk); #1; src = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(CYC * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1; armed = 1;

        tag = "R1";
        peek(5'h04); chk("R1 mask A byte0", rdata, 8'hFF);
        peek(5'h05); chk("R1 mask A byte1", rdata, 8'h0F);
        peek(5'h0D); chk("R1 mask B byte1", rdata, 8'h0F);
        peek(5'h00); chk("R1 status A byte0", rdata, 8'h00);
        peek(5'h1F); chk("R1 control", rdata, 8'h00);
        chk("R1 irq lines", {6'b0, irq_a_n, irq_b_n}, 8'h03);

        tag = "R3";
        setsrc('1); idle(5); peek(5'h00); chk("R3 no-trigger byte0", rdata, 8'h00);
        peek(5'h01); chk("R3 no-trigger byte1", rdata, 8'h00);
        setsrc('0); idle(5); peek(5'h00); chk("R3 no-trigger falling", rdata, 8'h00);

        tag = "R2";
        wreg(5'h10, 8'h08); wreg(5'h11, 8'h01); wreg(5'h12, 8'h80);
        tag = "R4";
        peek(5'h00);
        setsrc(12'h002);
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R4 not yet after two edges", rdata, 8'h00);
        @(negedge clk);
        chk("R4 latched on third edge", rdata, 8'h02);
        tag = "R2";
        setsrc(12'h012); idle(5); peek(5'h00); chk("R2 rise of fall-only src ignored", rdata, 8'h02);
        setsrc(12'h002); idle(5); peek(5'h00); chk("R2 fall of src4", rdata, 8'h12);
        setsrc(12'h802); idle(5); peek(5'h01); chk("R2 rise of src11", rdata, 8'h08);
        tag = "R5";
        peek(5'h08); chk("R5 line B byte0", rdata, 8'h12);
        peek(5'h09); chk("R5 line B byte1", rdata, 8'h08);

        tag = "R6";
        peek(5'h00); chk("R6 all masked", {6'b0, irq_a_n, irq_b_n}, 8'h03);
        wreg(5'h04, 8'hEF); peek(5'h00);
        chk("R6 unmask src4 on A", {6'b0, irq_a_n, irq_b_n}, 8'h01);

        tag = "R8";
        wreg(5'h00, 8'h10); peek(5'h00); chk("R8 w1c clears src4", rdata, 8'h02);
        chk("R6 line A released", {7'b0, irq_a_n}, 8'h01);
        peek(5'h08); chk("R5 line B untouched by A clear", rdata, 8'h12);
        rreg(5'h08, d); chk("R8 read value", d, 8'h12);
        peek(5'h08); chk("R8 read does not clear", rdata, 8'h12);

        tag = "R9";
        wreg(5'h11, 8'h03);
        setsrc(12'h812); idle(5); setsrc(12'h802); idle(5);
        peek(5'h00); chk("R9 first event", rdata, 8'h12);
        wreg(5'h00, 8'h10); peek(5'h00); chk("R9 buffered event reappears", rdata, 8'h12);
        wreg(5'h00, 8'h10); peek(5'h00); chk("R9 second clear empties", rdata, 8'h02);

        tag = "R10";
        wreg(5'h1F, 8'h02);
        setsrc(12'h812); idle(5); setsrc(12'h802); idle(5);
        wreg(5'h00, 8'h10); peek(5'h00); chk("R10 one clear suffices", rdata, 8'h02);

        tag = "R7";
        wreg(5'h1F, 8'h01);
        rreg(5'h00, d); chk("R7 read returns", d, 8'h02);
        peek(5'h00); chk("R7 read cleared", rdata, 8'h00);
        wreg(5'h08, 8'hFF); peek(5'h08); chk("R7 write ignored", rdata, 8'h12);
        rreg(5'h08, d); peek(5'h08); chk("R7 held bit reappears on B", rdata, 8'h10);
        rreg(5'h08, d); peek(5'h08); chk("R7 second read empties", rdata, 8'h00);

        tag = "R11";
        wreg(5'h10, 8'h0C);
        setsrc(12'h800); idle(5); peek(5'h00); chk("R11 setup", rdata, 8'h02);
        setsrc(12'h802);
        @(posedge clk); @(posedge clk); #1 rd = 1; addr = 5'h00;
        @(negedge clk); chk("R11 value before race", rdata, 8'h02);
        @(posedge clk); #1 rd = 0;
        @(negedge clk); chk("R11 event kept on clearing cycle", rdata, 8'h02);

        tag = "R12";
        wreg(5'h19, 8'h04);
        peek(5'h01); chk("R12 swset line A", rdata, 8'h0C);
        peek(5'h09); chk("R12 swset line B", rdata, 8'h0C);

        tag = "R13";
        peek(5'h1E); chk("R13 unmapped", rdata, 8'h00);
        peek(5'h12); chk("R13 edge byte2", rdata, 8'h80);
        peek(5'h11); chk("R13 edge byte1", rdata, 8'h03);
        peek(5'h1F); chk("R13 control readback", rdata, 8'h01);
        wreg(5'h05, 8'hFF); peek(5'h05); chk("R13 unused mask bits", rdata, 8'h0F);

        tag = "R11";
        for (int k = 0; k < 8; k++) begin
            setsrc(src ^ 12'h002);
            idle(k);
            wreg(5'h00, 8'hFF);
            rreg(5'h08, d);
        end

        tag = "R4";
        for (int n = 0; n < 4000; n++) begin
            int r;
            @(posedge clk); #1;
            wr = 0; rd = 0;
            r = $urandom % 10;
            if (r == 0) begin
                wr = 1; addr = 5'($urandom % 32); wdata = 8'($urandom);
            end else if (r < 3) begin
                rd = 1; addr = ($urandom % 2) ? 5'h08 : 5'h00;
                if ($urandom % 2) addr = addr + 5'd1;
            end else begin
                addr = 5'($urandom % 32);
            end
            if ($urandom % 3 == 0) src = src ^ (12'h001 << ($urandom % N));
        end
        @(posedge clk); #1 wr = 0; rd = 0;
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule